// File: doc/BRIEF.md
# Continuous Ones/Zeros Pattern Detector

This block watches the received bit stream that a DPSK/QAM data demodulator produces. It reports on a 2-bit code when the line carries a steady run of ones or zeros. A self-synchronising descrambler sits inside the block and can be switched on or off. One pair of run detectors looks at the descrambler output. A third detector looks at the raw received bits ahead of the descrambler. With the descrambler on, the block can therefore tell a run of scrambled ones from a run of plain ones, and a run of plain ones takes priority in the report.

Bits are qualified by a one-cycle valid strobe, and cycles without it leave all state untouched. A line is declared steady after a fixed number of identical bits in a row. The report is withdrawn on the first bit that breaks the run. When software changes the descrambler setting, the block starts counting again from nothing. The report does not depend on any receive-energy indication; the block has no such input.

Top module: `pattern_status_det`

## Requirements
- R1: While rst_n is low and after it rises, pattern_code is 00 and all run counts are empty.
- R2: With descr_en high, the descrambled bit equals rx_bit XOR d14 XOR d17. Here dk is the k-th previous received bit taken with bit_valid. With descr_en low, the descrambled bit equals rx_bit. The history register takes every valid bit whatever the setting.
- R3: After RUN_LEN (32) consecutive valid bits of value 1 at the descrambler output, pattern_code is 10. With the descrambler on, this is a run of scrambled ones. With it off, it is a run of plain ones.
- R4: After RUN_LEN consecutive valid bits of value 0 at the descrambler output, pattern_code is 01.
- R5: With descr_en high, RUN_LEN consecutive valid 1s on rx_bit ahead of the descrambler give pattern_code 11, and this overrides code 10.
- R6: A run is declared in the cycle after the clock edge that takes its RUN_LEN-th bit. After RUN_LEN-1 bits the code is still 00.
- R7: The first valid bit that differs from a declared run withdraws it: the code drops from that run's value after the edge that takes the bit.
- R8: Cycles with bit_valid low change neither the run counts, the descrambler history nor pattern_code.
- R9: On the first edge where descr_en differs from its registered value, all run counts clear and pattern_code becomes 00. A bit valid in that cycle is not counted, though it still enters the descrambler history.
- R10: pattern_code is never 11 while the registered descrambler enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Marks rx_bit as a new received bit |
| rx_bit | input | 1 | Received data bit from the demodulator |
| descr_en | input | 1 | 1 = descrambler active, 0 = bits pass straight through |
| pattern_code | output | 2 | 00 none, 01 zeros, 10 ones after descrambler, 11 raw ones |

## Verification
The stimulus covers runs of plain ones and plain zeros with the descrambler off. With it on, the stimulus adds raw all-ones, which must report 11 and not 10. It also adds bits chosen from the bench's own history so that the descrambled output is all ones while the raw stream is not, and the same for zeros; these separate the detector after the descrambler from the one ahead of it. Runs of RUN_LEN-1 bits show the exact threshold, and single breaking bits show withdrawal. Runs split by idle cycles show that invalid cycles are ignored. Enable toggles with a valid bit in the same cycle show the clear and the discarded bit.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [1:0] {
        PAT_NONE     = 2'b00,
        PAT_ZEROS    = 2'b01,
        PAT_ONES     = 2'b10,
        PAT_RAW_ONES = 2'b11
    } pat_code_e;

endpackage

// File: rtl/pds_descrambler.sv
module pds_descrambler #(
    parameter int HIST_LEN = 17,
    parameter int TAP_NEAR = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic din,
    input  logic enable,
    output logic dout
);

    typedef struct packed {
        logic [HIST_LEN-1:0] hist;
    } descr_state_t;

    descr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.hist = {st_q.hist[HIST_LEN-2:0], din};
        end
        if (enable) begin
            dout = din ^ st_q.hist[TAP_NEAR-1] ^ st_q.hist[HIST_LEN-1];
        end else begin
            dout = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.hist)); // R8

    AST_HIST_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> st_q.hist[0] == $past(din)); // R2

endmodule

// File: rtl/pds_run_det.sv
module pds_run_det #(
    parameter int   RUN_LEN = 32,
    parameter logic TARGET  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic valid,
    input  logic din,
    output logic hit
);

    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (valid) begin
            if (din == TARGET) begin
                if (st_q.cnt != LIMIT) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
        hit = (st_q.cnt == LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RUN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clr && din != TARGET) |=> !hit); // R7

    AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hit); // R9

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> ($past(valid) && $past(din) == TARGET)); // R6

    AST_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clr) |=> $stable(hit)); // R8

endmodule

// File: rtl/pattern_status_det.sv
module pattern_status_det #(
    parameter int RUN_LEN  = 32,
    parameter int HIST_LEN = 17,
    parameter int TAP_NEAR = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       rx_bit,
    input  logic       descr_en,
    output logic [1:0] pattern_code
);
    import pds_pkg::*;

    typedef struct packed {
        logic en;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       en_change;
    logic       descr_bit;
    logic [1:0] post_hit;
    logic       raw_hit;
    pat_code_e  code;

    pds_descrambler #(
        .HIST_LEN (HIST_LEN),
        .TAP_NEAR (TAP_NEAR)
    ) u_descr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_valid),
        .din      (rx_bit),
        .enable   (descr_en),
        .dout     (descr_bit)
    );

    for (genvar p = 0; p < 2; p++) begin : g_post
        pds_run_det #(
            .RUN_LEN (RUN_LEN),
            .TARGET  (1'(p))
        ) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (en_change),
            .valid (bit_valid),
            .din   (descr_bit),
            .hit   (post_hit[p])
        );
    end

    pds_run_det #(
        .RUN_LEN (RUN_LEN),
        .TARGET  (1'b1)
    ) u_raw_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (en_change),
        .valid (bit_valid),
        .din   (rx_bit),
        .hit   (raw_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.en   = descr_en;
        en_change = (descr_en != st_q.en);
        if (st_q.en && raw_hit) begin
            code = PAT_RAW_ONES;
        end else if (post_hit[1]) begin
            code = PAT_ONES;
        end else if (post_hit[0]) begin
            code = PAT_ZEROS;
        end else begin
            code = PAT_NONE;
        end
        pattern_code = code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_POST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(post_hit[0] && post_hit[1])); // R4

    AST_RAW_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_code == 2'b11) |-> st_q.en); // R10

    AST_EN_CHANGE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        en_change |=> pattern_code == 2'b00); // R9

    AST_RAW_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && raw_hit && post_hit[1]) |-> pattern_code != 2'b10); // R5

endmodule

// File: tb/pattern_status_det_bench.sv
module pattern_status_det_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       rx_bit = 1'b0;
    logic       descr_en = 1'b0;
    logic [1:0] pattern_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      req_q[$];

    logic [16:0] m_hist = '0;
    int          m_raw = 0;
    int          m_one = 0;
    int          m_zero = 0;
    logic        m_en = 1'b0;

    always #2.5 clk = ~clk;

    pattern_status_det u_pattern_status_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_valid    (bit_valid),
        .rx_bit       (rx_bit),
        .descr_en     (descr_en),
        .pattern_code (pattern_code)
    );

    function automatic logic [1:0] model_code();
        if (m_en && m_raw >= 32) return 2'b11;
        if (m_one >= 32) return 2'b10;
        if (m_zero >= 32) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic src_for(input logic want);
        return want ^ m_hist[13] ^ m_hist[16];
    endfunction

    task automatic step(input logic v, input logic b, input logic en, input string req);
        logic o;
        @(negedge clk);
        bit_valid = v;
        rx_bit    = b;
        descr_en  = en;
        if (en != m_en) begin
            m_raw = 0; m_one = 0; m_zero = 0;
            m_en  = en;
            if (v) m_hist = {m_hist[15:0], b};
        end else if (v) begin
            o = en ? (b ^ m_hist[13] ^ m_hist[16]) : b;
            m_raw  = b ? m_raw + 1 : 0;
            m_one  = o ? m_one + 1 : 0;
            m_zero = o ? 0 : m_zero + 1;
            m_hist = {m_hist[15:0], b};
        end
        exp_q.push_back(model_code());
        req_q.push_back(req);
    endtask

    task automatic run(input int n, input logic b, input logic en, input string req);
        for (int i = 0; i < n; i++) step(1'b1, b, en, req);
    endtask

    task automatic run_descr(input int n, input logic want, input string req);
        for (int i = 0; i < n; i++) step(1'b1, src_for(want), 1'b1, req);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : monitor
        logic [1:0] e;
        string r;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                r = req_q.pop_front();
                checks++;
                if (pattern_code !== e) begin
                    failures++;
                    $display("FAIL %s: pattern_code=%b expected=%b", r, pattern_code, e);
                end
            end
        end
    end

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        checks++;
        if (pattern_code !== 2'b00) begin
            failures++;
            $display("FAIL R1: pattern_code=%b expected=00 in reset", pattern_code);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, "R1");
        // plain ones: 31 bits no report, 32nd declares
        run(31, 1'b1, 1'b0, "R6");
        run(3, 1'b1, 1'b0, "R3");
        step(1'b1, 1'b0, 1'b0, "R7");
        // plain zeros
        run(31, 1'b0, 1'b0, "R6");
        run(2, 1'b0, 1'b0, "R4");
        // idle cycles inside a run of ones must not break or count
        run(20, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, "R8");
        run(11, 1'b1, 1'b0, "R8");
        run(2, 1'b1, 1'b0, "R3");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, "R8");
        // raw ones with descrambler off stay at code 10
        run(5, 1'b1, 1'b0, "R10");
        // enable change with a valid bit: clear, bit discarded
        step(1'b1, 1'b1, 1'b1, "R9");
        run(31, 1'b1, 1'b1, "R5");
        run(4, 1'b1, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b1, "R7");
        // scrambled ones: descrambled output all ones, raw stream mixed
        run_descr(40, 1'b1, "R3");
        run_descr(1, 1'b0, "R7");
        // scrambled zeros
        run_descr(40, 1'b0, "R4");
        run_descr(5, 1'b1, "R2");
        run_descr(30, 1'b0, "R2");
        // disable again while a zero run builds: clears
        step(1'b1, 1'b0, 1'b0, "R9");
        run(31, 1'b0, 1'b0, "R9");
        run(2, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b1, "R9");
        run(32, 1'b1, 1'b1, "R5");
        step(1'b0, 1'b1, 1'b0, "R10");
        run(3, 1'b1, 1'b0, "R10");
        @(negedge clk);
        bit_valid = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule